// File: doc/BRIEF.md
# Two-Channel Event Timer with Write Settling

This block holds a 64-bit up-counter and two comparator channels behind a small word-addressed register port. Channel 0 is periodic. Each time the counter equals its comparator, the comparator moves forward by the programmed period, so the channel can mark the wrap of a software time base. Channel 1 is a one-shot event comparator that holds a 64-bit absolute deadline. Interrupts are level signals. Each one stays high until software clears it through a write-one-to-clear register.

Writes to the channel-1 deadline, to the channel-1 enable and to the interrupt-clear register are not applied at once. Each one waits through a settling interval of `SETTLE` clock cycles. During that interval the old value stays in force and a per-resource busy flag reads as 1. A write to a resource that is still busy is dropped, and the block pulses an error output. After the global enable rises, a "counter valid" busy flag also shows for `SETTLE` cycles. A comparator match reaches the pending status after `LAT` cycles, which models the interrupt latency. Software reads the counter as two 32-bit words. It reads the high word, then the low word, then the high word again, and it retries when the two high words differ.

Top module: `evt_timer`

## Requirements
- R1: Word addresses: 0 = control (bit 0 global enable), 1 = busy flags, 2/3 = counter low/high word, 4 = channel-0 interrupt enable (bit 0), 5/6 = channel-0 comparator low/high, 7 = channel-1 interrupt enable (bit 0), 8/9 = channel-1 deadline low/high, 10 = pending status (bit N = channel N) on read and clear mask on write. While the enable is 1, the counter adds one on every clock edge. While it is 0, the counter holds its value.
- R2: A write to address 2 or 3 loads that counter word only while the enable is 0. While the enable is 1, such a write has no effect.
- R3: Writing address 5 or 6 sets that word of both the channel-0 comparator and the channel-0 period. When the enabled counter equals the comparator, the comparator advances by the period, so the channel fires again one period later.
- R4: Channel 1 fires once, at the edge where the enabled counter equals its deadline. It does not re-arm.
- R5: A match seen at clock edge k sets the pending bit at edge k+LAT. The bit stays set until it is cleared. `irq_o[N]` follows pending bit N AND channel N's enable, one cycle later.
- R6: A write to address 10 clears the pending bits given by `wr_data[1:0]`, at edge SETTLE+1 after the write edge. If a new match sets a bit on that same edge, the bit stays set.
- R7: Address 8 only holds the low word. A write to address 9 starts settling of {wr_data, held low word}. Busy flag bit 0 reads 1 for SETTLE cycles, the old deadline stays in force and reads back on addresses 8/9, and the new value takes effect after settling.
- R8: A write to address 7 settles in the same way before the channel-1 enable changes. Its busy flag is bit 1.
- R9: Busy flag bit 3 reads 1 for SETTLE cycles after a control write raises the enable from 0 to 1.
- R10: Busy flag bit 2 marks a pending clear write. Bit 4 is the OR of bits 0 to 3.
- R11: A write to address 7, 9 or 10 while that resource is busy is ignored, and `err_o` is 1 for the following cycle.
- R12: Read data is registered and shows the addressed register one cycle after `rd_addr` is applied. A high/low/high read across a carry returns two high words that differ by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timer tick |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 2 | Level interrupts, bit N = channel N |
| err_o | output | 1 | One-cycle pulse for a write dropped while busy |

## Verification
The interesting collision is a settled clear of a pending bit landing on the same edge as a fresh match of that channel reaching the status after its latency. The bench provokes it by issuing clears of channel 0 at many spacings while channel 0 fires every 20 cycles, so some clears land exactly on a delayed match. A cycle-accurate behavioural model in the bench decides, on each edge, whether the set or the clear should win and compares read data, interrupts and the error pulse against the design on every clock. A second collision is a write that arrives while the same resource is still settling, which is judged by the error pulse and by the read-back of the untouched value.

// File: rtl/evt_tmr_pkg.sv
`timescale 1ns/1ps
package evt_tmr_pkg;
  localparam int AW  = 4;
  localparam int NCH = 2;
  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_BUSY  = 4'd1;
  localparam logic [AW-1:0] A_CNTL  = 4'd2;
  localparam logic [AW-1:0] A_CNTH  = 4'd3;
  localparam logic [AW-1:0] A_C0CFG = 4'd4;
  localparam logic [AW-1:0] A_C0L   = 4'd5;
  localparam logic [AW-1:0] A_C0H   = 4'd6;
  localparam logic [AW-1:0] A_C1CFG = 4'd7;
  localparam logic [AW-1:0] A_C1L   = 4'd8;
  localparam logic [AW-1:0] A_C1H   = 4'd9;
  localparam logic [AW-1:0] A_PEND  = 4'd10;
endpackage

// File: rtl/evt_settle_slot.sv
`timescale 1ns/1ps
// Holds a written value for SETTLE cycles before making it effective.
module evt_settle_slot #(
  parameter int W = 32,
  parameter int SETTLE = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         reject_o,
  output logic         commit_o,
  output logic [W-1:0] data_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] left_q;
  logic [W-1:0]  pend_q;

  assign busy_o   = (left_q != '0);
  assign reject_o = start_i && busy_o;
  assign commit_o = (left_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      pend_q <= '0;
      data_o <= INIT;
    end else if (start_i && !busy_o) begin
      left_q <= CW'(SETTLE);
      pend_q <= data_i;
    end else if (busy_o) begin
      left_q <= left_q - 1'b1;
      if (commit_o) data_o <= pend_q;
    end
  end

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  // R7
  old_value_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !commit_o) |=> $stable(data_o));
  // R11
  drop_write_chk: assert property (@(posedge clk) disable iff (rst)
    reject_o |=> $stable(pend_q));
endmodule

// File: rtl/evt_match_delay.sv
`timescale 1ns/1ps
// Fixed latency line from comparator match to status set.
module evt_match_delay #(
  parameter int N = 2,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] match_i,
  output logic [N-1:0] match_o
);
  logic [N-1:0] stage_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= match_i;
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= '0;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign match_o = stage_q[LAT-1];
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
  import evt_tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int SETTLE = 4,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [NCH-1:0] irq_o,
  output logic          err_o
);
  localparam int CNT_W = 2 * DW;
  localparam int VW    = $clog2(SETTLE + 1);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q, cmp0_q, per0_q;
  logic             ie0_q;
  logic [DW-1:0]    c1_lo_q;
  logic [VW-1:0]    vleft_q;
  logic [NCH-1:0]   pend_q, match, match_dly;
  logic             clr_apply_q;

  logic ld_lo, ld_hi, c1_start, cfg_start, clr_start, en_rise;
  assign ld_lo     = wr_en && (wr_addr == A_CNTL) && !en_q;
  assign ld_hi     = wr_en && (wr_addr == A_CNTH) && !en_q;
  assign c1_start  = wr_en && (wr_addr == A_C1H);
  assign cfg_start = wr_en && (wr_addr == A_C1CFG);
  assign clr_start = wr_en && (wr_addr == A_PEND);
  assign en_rise   = wr_en && (wr_addr == A_CTRL) && wr_data[0] && !en_q;

  logic             c1_busy, c1_rej, c1_commit;
  logic [CNT_W-1:0] cmp1;
  logic             cfg_busy, cfg_rej, cfg_commit, ie1;
  logic             clr_busy, clr_rej, clr_commit;
  logic [NCH-1:0]   clr_mask;

  evt_settle_slot #(.W(CNT_W), .SETTLE(SETTLE), .INIT({CNT_W{1'b1}})) u_cmp1 (
    .clk(clk), .rst(rst), .start_i(c1_start), .data_i({wr_data, c1_lo_q}),
    .busy_o(c1_busy), .reject_o(c1_rej), .commit_o(c1_commit), .data_o(cmp1));

  evt_settle_slot #(.W(1), .SETTLE(SETTLE), .INIT(1'b0)) u_cfg1 (
    .clk(clk), .rst(rst), .start_i(cfg_start), .data_i(wr_data[0]),
    .busy_o(cfg_busy), .reject_o(cfg_rej), .commit_o(cfg_commit), .data_o(ie1));

  evt_settle_slot #(.W(NCH), .SETTLE(SETTLE), .INIT('0)) u_clr (
    .clk(clk), .rst(rst), .start_i(clr_start), .data_i(wr_data[NCH-1:0]),
    .busy_o(clr_busy), .reject_o(clr_rej), .commit_o(clr_commit), .data_o(clr_mask));

  assign match = {en_q && (cnt_q == cmp1), en_q && (cnt_q == cmp0_q)};

  evt_match_delay #(.N(NCH), .LAT(LAT)) u_dly (
    .clk(clk), .rst(rst), .match_i(match), .match_o(match_dly));

  logic       v_busy;
  logic [4:0] busy_vec;
  assign v_busy   = (vleft_q != '0);
  assign busy_vec = {c1_busy | cfg_busy | clr_busy | v_busy, v_busy, clr_busy, cfg_busy, c1_busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      vleft_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) en_q <= wr_data[0];
      if (en_rise)     vleft_q <= VW'(SETTLE);
      else if (v_busy) vleft_q <= vleft_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (ld_lo) cnt_q[DW-1:0] <= wr_data;
    else if (ld_hi) cnt_q[CNT_W-1:DW] <= wr_data;
    else if (en_q)  cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp0_q  <= '1;
      per0_q  <= '0;
      ie0_q   <= 1'b0;
      c1_lo_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_C0L) begin
        cmp0_q[DW-1:0] <= wr_data;
        per0_q[DW-1:0] <= wr_data;
      end else if (wr_en && wr_addr == A_C0H) begin
        cmp0_q[CNT_W-1:DW] <= wr_data;
        per0_q[CNT_W-1:DW] <= wr_data;
      end else if (match[0]) begin
        cmp0_q <= cmp0_q + per0_q;
      end
      if (wr_en && wr_addr == A_C0CFG) ie0_q <= wr_data[0];
      if (wr_en && wr_addr == A_C1L)   c1_lo_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      clr_apply_q <= 1'b0;
      irq_o       <= '0;
      err_o       <= 1'b0;
    end else begin
      clr_apply_q <= clr_commit;
      pend_q      <= (pend_q & ~(clr_apply_q ? clr_mask : '0)) | match_dly;
      irq_o       <= pend_q & {ie1, ie0_q};
      err_o       <= c1_rej | cfg_rej | clr_rej;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:  rd_data <= DW'(en_q);
        A_BUSY:  rd_data <= DW'(busy_vec);
        A_CNTL:  rd_data <= cnt_q[DW-1:0];
        A_CNTH:  rd_data <= cnt_q[CNT_W-1:DW];
        A_C0CFG: rd_data <= DW'(ie0_q);
        A_C0L:   rd_data <= cmp0_q[DW-1:0];
        A_C0H:   rd_data <= cmp0_q[CNT_W-1:DW];
        A_C1CFG: rd_data <= DW'(ie1);
        A_C1L:   rd_data <= cmp1[DW-1:0];
        A_C1H:   rd_data <= cmp1[CNT_W-1:DW];
        A_PEND:  rd_data <= DW'(pend_q);
        default: rd_data <= '0;
      endcase
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !ld_lo && !ld_hi) |=> $stable(cnt_q));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    match_dly[0] |=> pend_q[0]);
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_apply_q && clr_mask[0] && !match_dly[0]) |=> !pend_q[0]);
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (c1_start && c1_busy) |=> err_o);
  // R7
  cmp1_settled_chk: assert property (@(posedge clk) disable iff (rst)
    c1_commit |=> !c1_busy);
  // R8
  cfg1_settled_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_commit |=> !cfg_busy);
  // R9
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> busy_vec[3]);
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
  import evt_tmr_pkg::*;
  localparam int SETTLE = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_o;
  logic        err_o;

  evt_timer #(.DW(32), .SETTLE(SETTLE), .LAT(LAT)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .err_o(err_o));

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", t, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic        m_en, m_ie0, m_ie1, m_cfgp, m_err, m_app;
  logic [63:0] m_cnt, m_cmp0, m_per0, m_cmp1, m_c1p;
  logic [31:0] m_hold, m_rd;
  logic [1:0]  m_pend, m_irq, m_clre, m_clrp;
  int          c1_left, cfg_left, clr_left, v_left;
  logic [1:0]  q[$];

  always @(posedge clk) begin
    logic [1:0] mt, d, cm;
    logic [4:0] st;
    if (rst) begin
      m_en = 0; m_ie0 = 0; m_ie1 = 0; m_cfgp = 0; m_err = 0; m_app = 0;
      m_cnt = 0; m_cmp0 = '1; m_per0 = 0; m_cmp1 = '1; m_c1p = 0;
      m_hold = 0; m_rd = 0; m_pend = 0; m_irq = 0; m_clre = 0; m_clrp = 0;
      c1_left = 0; cfg_left = 0; clr_left = 0; v_left = 0;
      q.delete();
      for (int i = 0; i < LAT; i++) q.push_back(2'b00);
    end else begin
      mt = {m_en && (m_cnt == m_cmp1), m_en && (m_cnt == m_cmp0)};
      d = q.pop_front();
      q.push_back(mt);
      st = {(c1_left + cfg_left + clr_left + v_left) != 0, v_left != 0,
            clr_left != 0, cfg_left != 0, c1_left != 0};
      case (rd_addr)
        A_CTRL:  m_rd = {31'd0, m_en};
        A_BUSY:  m_rd = {27'd0, st};
        A_CNTL:  m_rd = m_cnt[31:0];
        A_CNTH:  m_rd = m_cnt[63:32];
        A_C0CFG: m_rd = {31'd0, m_ie0};
        A_C0L:   m_rd = m_cmp0[31:0];
        A_C0H:   m_rd = m_cmp0[63:32];
        A_C1CFG: m_rd = {31'd0, m_ie1};
        A_C1L:   m_rd = m_cmp1[31:0];
        A_C1H:   m_rd = m_cmp1[63:32];
        A_PEND:  m_rd = {30'd0, m_pend};
        default: m_rd = 0;
      endcase
      m_irq = m_pend & {m_ie1, m_ie0};
      m_err = wr_en && ((wr_addr == A_C1H && c1_left != 0) ||
                        (wr_addr == A_C1CFG && cfg_left != 0) ||
                        (wr_addr == A_PEND && clr_left != 0));
      cm = m_app ? m_clre : 2'b00;
      m_pend = (m_pend & ~cm) | d;
      m_app = (clr_left == 1);
      if (wr_en && wr_addr == A_PEND && clr_left == 0) begin
        clr_left = SETTLE; m_clrp = wr_data[1:0];
      end else if (clr_left != 0) begin
        if (clr_left == 1) m_clre = m_clrp;
        clr_left--;
      end
      if (wr_en && wr_addr == A_C1H && c1_left == 0) begin
        c1_left = SETTLE; m_c1p = {wr_data, m_hold};
      end else if (c1_left != 0) begin
        if (c1_left == 1) m_cmp1 = m_c1p;
        c1_left--;
      end
      if (wr_en && wr_addr == A_C1CFG && cfg_left == 0) begin
        cfg_left = SETTLE; m_cfgp = wr_data[0];
      end else if (cfg_left != 0) begin
        if (cfg_left == 1) m_ie1 = m_cfgp;
        cfg_left--;
      end
      if (wr_en && wr_addr == A_C1L) m_hold = wr_data;
      if (wr_en && wr_addr == A_C0CFG) m_ie0 = wr_data[0];
      if (wr_en && wr_addr == A_C0L) begin
        m_cmp0[31:0] = wr_data; m_per0[31:0] = wr_data;
      end else if (wr_en && wr_addr == A_C0H) begin
        m_cmp0[63:32] = wr_data; m_per0[63:32] = wr_data;
      end else if (mt[0]) m_cmp0 = m_cmp0 + m_per0;
      if (wr_en && wr_addr == A_CNTL && !m_en) m_cnt[31:0] = wr_data;
      else if (wr_en && wr_addr == A_CNTH && !m_en) m_cnt[63:32] = wr_data;
      else if (m_en) m_cnt = m_cnt + 64'd1;
      if (wr_en && wr_addr == A_CTRL && wr_data[0] && !m_en) v_left = SETTLE;
      else if (v_left != 0) v_left--;
      if (wr_en && wr_addr == A_CTRL) m_en = wr_data[0];
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(tag, "rd_data", {32'd0, rd_data}, {32'd0, m_rd});
      chk("R5", "irq_o", {62'd0, irq_o}, {62'd0, m_irq});
      chk("R11", "err_o", {63'd0, err_o}, {63'd0, m_err});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a);
    @(negedge clk);
    rd_addr = a;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] h1, l1, h2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    for (int a = 0; a <= 10; a++) rd(4'(a));

    tag = "R2";
    wr(A_CNTL, 32'd0);
    wr(A_CNTH, 32'd0);
    rd(A_CNTL);

    tag = "R3";
    wr(A_C0L, 32'd20);
    wr(A_C0H, 32'd0);
    wr(A_C0CFG, 32'd1);

    tag = "R7";
    wr(A_C1L, 32'd50);
    rd(A_BUSY);
    wr(A_C1H, 32'd0);
    rd(A_C1L);
    idle(2);
    rd(A_BUSY);
    idle(SETTLE);
    rd(A_C1L);
    idle(1);

    tag = "R8";
    rd(A_BUSY);
    wr(A_C1CFG, 32'd1);
    idle(1);
    rd(A_C1CFG);
    idle(SETTLE);

    tag = "R9";
    rd(A_BUSY);
    wr(A_CTRL, 32'd1);
    idle(SETTLE + 1);

    tag = "R3";
    rd(A_PEND);
    idle(30);
    rd(A_C0L);
    idle(15);

    tag = "R6";
    rd(A_PEND);
    wr(A_PEND, 32'd1);

    tag = "R10";
    rd(A_BUSY);
    wr(A_PEND, 32'd2);
    idle(SETTLE);

    tag = "R4";
    rd(A_PEND);
    idle(10);
    wr(A_PEND, 32'd2);
    idle(SETTLE + 2);
    idle(40);

    tag = "R6";
    rd(A_PEND);
    for (int k = 0; k < 24; k++) begin
      wr(A_PEND, 32'd1);
      idle(SETTLE + (k % 5));
    end

    tag = "R11";
    wr(A_C1L, 32'd9);
    wr(A_C1H, 32'd7);
    wr(A_C1H, 32'd8);
    rd(A_C1H);
    wr(A_C1CFG, 32'd0);
    wr(A_C1CFG, 32'd1);
    rd(A_C1CFG);
    idle(SETTLE + 2);

    tag = "R2";
    rd(A_CNTL);
    wr(A_CNTL, 32'd0);
    wr(A_CNTH, 32'd3);
    rd(A_CNTH);
    idle(2);

    tag = "R12";
    wr(A_CTRL, 32'd0);
    wr(A_CNTL, 32'hFFFF_FFFE);
    wr(A_CNTH, 32'd5);
    wr(A_CTRL, 32'd1);
    rd_addr = A_CNTH;
    @(negedge clk); h1 = rd_data; rd_addr = A_CNTL;
    @(negedge clk); l1 = rd_data; rd_addr = A_CNTH;
    @(negedge clk); h2 = rd_data;
    chk("R12", "tear high words", {32'd0, h2}, {32'd0, h1 + 32'd1});
    chk("R12", "first high", {32'd0, h1}, 64'd5);
    chk("R12", "low word", {32'd0, l1}, 64'hFFFF_FFFF);
    idle(3);
    finish_run();
  end
endmodule